// File: doc/BRIEF.md
# Edge and Level Pin Interrupt Controller

This block turns a group of input pins into per-channel interrupt requests. Each channel passes its pin through a two-stage synchroniser and then runs in one of two modes. In edge mode, a rising transition and a falling transition each have their own enable. A detected transition sets a sticky flag, and the flag holds the channel's request until software clears it. In level mode, the request follows the synchronised pin directly and never needs clearing. The second enable bit then selects whether the pin is active high or active low.

Software reaches the block through a simple synchronous port: a write strobe, a word address, write data and combinational read data. The two enable vectors are never written directly. Each enable vector has one address that sets bits and another that clears bits, so one channel can be changed without a read-modify-write that could race with another agent. Flags are cleared by writing ones, either per flag kind or for both kinds at once through the status address.

Top module: `pin_irq_ctrl`

## Requirements
- R1: The mode register at address 0x0 is read/write. Bit i = 0 puts channel i in edge mode and bit i = 1 puts it in level mode.
- R2: The rise/level enable vector reads at address 0x1. Writing 1s to address 0x2 sets the matching bits and writing 1s to address 0x3 clears them. Zero bits in either write leave their enable bits unchanged.
- R3: The fall/polarity enable vector reads at address 0x4. Writing 1s to address 0x5 sets the matching bits and writing 1s to address 0x6 clears them. Zero bits leave their enable bits unchanged.
- R4: In edge mode with the rise enable set, a 0-to-1 pin change sets the channel's rise flag, which reads at address 0x7. The request goes high after the third rising clock edge that follows the pin change.
- R5: In edge mode with the fall enable set, a 1-to-0 pin change sets the channel's fall flag, which reads at address 0x8. With both enables set, either transition sets its own flag.
- R6: In edge mode, the request stays high while either flag is set, even after the pin returns to its earlier level.
- R7: A transition whose enable is clear sets no flag.
- R8: In level mode, the request is high when the rise/level enable is set and the synchronised pin equals the polarity bit (1 = active high, 0 = active low). The request follows the pin two clock edges after it changes, needs no clear, and sets no flag.
- R9: Writing 1s to address 0x7 clears only those rise flags. Writing 1s to address 0x8 clears only those fall flags.
- R10: Address 0x9 reads the request vector. Writing 1s there clears both flags of each selected channel.
- R11: If an edge is detected in the same cycle that software clears that flag, the flag ends up set.
- R12: After reset, all channels are in edge mode, all enables and flags read 0, and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N | Asynchronous pin inputs, one per channel |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | N | Write data, one bit per channel |
| rdata_o | output | N | Read data for addr_i, combinational |
| irq_o | output | N | Per-channel interrupt requests |

## Verification
Some properties are checked on every cycle: enable set/clear semantics, the rule that a clear write removes a flag when no edge is pending, flag stickiness, the absence of flags in level mode and of flags whose enable is off, and the link between an edge-mode flag and its request. Other behaviour only the bench's scenarios show. This covers the exact latency from a pin change to a request, the choice of polarity in level mode, the case where an edge coincides with a clear write, and the separation of rise and fall clears.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_MODE    = 4'h0;
  localparam logic [AW-1:0] A_REN     = 4'h1;
  localparam logic [AW-1:0] A_REN_SET = 4'h2;
  localparam logic [AW-1:0] A_REN_CLR = 4'h3;
  localparam logic [AW-1:0] A_FEN     = 4'h4;
  localparam logic [AW-1:0] A_FEN_SET = 4'h5;
  localparam logic [AW-1:0] A_FEN_CLR = 4'h6;
  localparam logic [AW-1:0] A_RFLG    = 4'h7;
  localparam logic [AW-1:0] A_FFLG    = 4'h8;
  localparam logic [AW-1:0] A_STAT    = 4'h9;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  mode_o,
  output logic [N-1:0]  ren_o,
  output logic [N-1:0]  fen_o
);
  logic [N-1:0] mode_q, ren_q, fen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_MODE:    mode_q <= wdata_i;
        A_REN_SET: ren_q  <= ren_q | wdata_i;
        A_REN_CLR: ren_q  <= ren_q & ~wdata_i;
        A_FEN_SET: fen_q  <= fen_q | wdata_i;
        A_FEN_CLR: fen_q  <= fen_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign ren_o  = ren_q;
  assign fen_o  = fen_q;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,   // 1 = level
  input  logic ren_i,
  input  logic fen_i,
  input  logic lvl_i,
  input  logic prev_i,
  input  logic rclr_i,
  input  logic fclr_i,
  output logic rflag_o,
  output logic fflag_o,
  output logic irq_o
);
  logic rflag_q, fflag_q, rise_ev, fall_ev;

  assign rise_ev = ~mode_i & ren_i & lvl_i & ~prev_i;
  assign fall_ev = ~mode_i & fen_i & ~lvl_i & prev_i;

  // a new edge outranks a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rflag_q <= 1'b0;
      fflag_q <= 1'b0;
    end else begin
      rflag_q <= rise_ev | (rflag_q & ~rclr_i);
      fflag_q <= fall_ev | (fflag_q & ~fclr_i);
    end
  end

  assign rflag_o = rflag_q;
  assign fflag_o = fflag_q;
  assign irq_o   = mode_i ? (ren_i & (lvl_i == fen_i)) : (rflag_q | fflag_q);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pin_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  irq_o
);
  logic [N-1:0] lvl, prev, mode, ren, fen, rflag, fflag, rclr, fclr;

  pin_irq_sync #(.N(N)) u_sync (
    .clk_i, .rst_ni, .pin_i, .lvl_o(lvl), .prev_o(prev)
  );

  pin_irq_cfg #(.N(N)) u_cfg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .mode_o(mode), .ren_o(ren), .fen_o(fen)
  );

  assign rclr = (we_i && (addr_i == A_RFLG || addr_i == A_STAT)) ? wdata_i : '0;
  assign fclr = (we_i && (addr_i == A_FFLG || addr_i == A_STAT)) ? wdata_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_ch
    pin_irq_chan u_ch (
      .clk_i, .rst_ni,
      .mode_i(mode[i]), .ren_i(ren[i]), .fen_i(fen[i]),
      .lvl_i(lvl[i]), .prev_i(prev[i]),
      .rclr_i(rclr[i]), .fclr_i(fclr[i]),
      .rflag_o(rflag[i]), .fflag_o(fflag[i]), .irq_o(irq_o[i])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = mode;
      A_REN:   rdata_o = ren;
      A_FEN:   rdata_o = fen;
      A_RFLG:  rdata_o = rflag;
      A_FFLG:  rdata_o = fflag;
      A_STAT:  rdata_o = irq_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  irq_o,
  input logic [N-1:0]  mode,
  input logic [N-1:0]  ren,
  input logic [N-1:0]  fen,
  input logic [N-1:0]  rflag,
  input logic [N-1:0]  fflag,
  input logic [N-1:0]  lvl,
  input logic [N-1:0]  prev
);
  p_ren_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_REN_SET) |=> ((($past(wdata_i) | $past(ren)) ^ ren) == '0));
  p_ren_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_REN_CLR) |=> (((~$past(wdata_i) & $past(ren)) ^ ren) == '0));
  p_fen_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FEN_SET) |=> ((($past(wdata_i) | $past(fen)) ^ fen) == '0));
  p_fen_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FEN_CLR) |=> (((~$past(wdata_i) & $past(fen)) ^ fen) == '0));
  p_edge_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mode & (rflag | fflag) & ~irq_o) == '0));
  p_no_rise_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rflag & ~$past(rflag) & ~$past(ren)) == '0));
  p_no_fall_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fflag & ~$past(fflag) & ~$past(fen)) == '0));
  p_level_no_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((rflag & ~$past(rflag)) | (fflag & ~$past(fflag))) & $past(mode)) == '0);
  p_level_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode & ~ren & irq_o) == '0));
  p_rflag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == A_RFLG || addr_i == A_STAT)) |=> (($past(rflag) & ~rflag) == '0));
  p_rclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RFLG && lvl == prev) |=> ((rflag & $past(wdata_i)) == '0));
  p_rclr_keeps_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RFLG) |=> (($past(fflag) & ~fflag) == '0));
  p_stat_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && lvl == prev) |=> (((rflag | fflag) & $past(wdata_i)) == '0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N(N)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .irq_o,
  .mode(mode), .ren(ren), .fen(fen), .rflag(rflag), .fflag(fflag),
  .lvl(lvl), .prev(prev)
);

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         we = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, irq;
  int n_run = 0, n_fail = 0;

  pin_irq_ctrl #(.N(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // {we, addr, data/expected}
  localparam logic [12:0] TBL [14] = '{
    {1'b1, 4'h0, 8'hA5}, {1'b0, 4'h0, 8'hA5}, {1'b1, 4'h0, 8'h00}, {1'b0, 4'h0, 8'h00},
    {1'b1, 4'h2, 8'h0F}, {1'b0, 4'h1, 8'h0F}, {1'b1, 4'h2, 8'h30}, {1'b0, 4'h1, 8'h3F},
    {1'b1, 4'h3, 8'h05}, {1'b0, 4'h1, 8'h3A}, {1'b1, 4'h5, 8'hC3}, {1'b1, 4'h6, 8'h03},
    {1'b0, 4'h4, 8'hC0}, {1'b1, 4'h3, 8'hFF}
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL R12 watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(2); rst_n = 1'b1;
    // R12 reset state
    rd(4'h0, 8'h00, "R12 mode"); rd(4'h1, 8'h00, "R12 ren"); rd(4'h4, 8'h00, "R12 fen");
    rd(4'h7, 8'h00, "R12 rflag"); rd(4'h8, 8'h00, "R12 fflag"); chk("R12 irq", irq, 8'h00);

    // R1 R2 R3 register vectors
    for (int k = 0; k < 14; k++) begin
      if (TBL[k][12]) wr(TBL[k][11:8], TBL[k][7:0]);
      else rd(TBL[k][11:8], TBL[k][7:0],
              TBL[k][11:8] == 4'h0 ? "R1 mode" : (TBL[k][11:8] == 4'h1 ? "R2 ren" : "R3 fen"));
    end
    rd(4'h1, 8'h00, "R2 clear all");
    wr(4'h6, 8'hC0); rd(4'h4, 8'h00, "R3 clear rest");

    // R4 rise on ch0, latency three edges
    wr(4'h2, 8'h01);
    @(negedge clk); pin[0] = 1'b1;
    step(2); chk("R4 not yet", irq & 8'h01, 8'h00);
    step(1); chk("R4 irq", irq & 8'h01, 8'h01);
    rd(4'h7, 8'h01, "R4 rflag");
    // R6 sticky, R7 no fall flag without enable
    @(negedge clk); pin[0] = 1'b0;
    step(4); chk("R6 sticky", irq & 8'h01, 8'h01);
    rd(4'h8, 8'h00, "R7 fall disabled");
    // R9 fall clear leaves rise flag, rise clear drops it
    wr(4'h8, 8'h01); chk("R9 fall clr only", irq & 8'h01, 8'h01);
    wr(4'h7, 8'h01); chk("R9 rise clr", irq & 8'h01, 8'h00);

    // R5 fall on ch1, R10 status clear
    wr(4'h5, 8'h02);
    @(negedge clk); pin[1] = 1'b1; step(4);
    rd(4'h7, 8'h00, "R7 rise disabled");
    @(negedge clk); pin[1] = 1'b0; step(4);
    rd(4'h8, 8'h02, "R5 fflag");
    rd(4'h9, 8'h02, "R10 status");
    wr(4'h9, 8'h02);
    rd(4'h8, 8'h00, "R10 cleared");
    chk("R10 irq low", irq & 8'h02, 8'h00);

    // R5 both edges on ch2
    wr(4'h2, 8'h04); wr(4'h5, 8'h04);
    @(negedge clk); pin[2] = 1'b1; step(4);
    rd(4'h7, 8'h04, "R5 both rise");
    wr(4'h9, 8'h04);
    @(negedge clk); pin[2] = 1'b0; step(4);
    rd(4'h8, 8'h04, "R5 both fall");
    wr(4'h9, 8'h04);

    // R8 level on ch3
    wr(4'h0, 8'h08); wr(4'h2, 8'h08); wr(4'h5, 8'h08);
    @(negedge clk); pin[3] = 1'b1;
    step(1); chk("R8 high early", irq & 8'h08, 8'h00);
    step(1); chk("R8 high", irq & 8'h08, 8'h08);
    @(negedge clk); pin[3] = 1'b0;
    step(2); chk("R8 follows pin", irq & 8'h08, 8'h00);
    wr(4'h6, 8'h08);
    chk("R8 active low", irq & 8'h08, 8'h08);
    rd(4'h7, 8'h00, "R8 no rflag"); rd(4'h8, 8'h00, "R8 no fflag");
    wr(4'h3, 8'h08);
    chk("R8 disabled", irq & 8'h08, 8'h00);

    // R11 edge detect coincides with clear write on ch4
    wr(4'h2, 8'h10);
    @(negedge clk); pin[4] = 1'b1;
    step(2); we = 1'b1; addr = 4'h7; wdata = 8'h10;
    @(negedge clk); we = 1'b0;
    chk("R11 set wins", irq & 8'h10, 8'h10);
    wr(4'h7, 8'h10);
    chk("R11 later clear", irq & 8'h10, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule